// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block takes a two-channel serial audio stream made of a bit clock, a word clock that marks the left and right halves of each frame, and one data line. It oversamples all three lines in the system clock domain and emits a parallel left/right sample pair with a one-cycle valid strobe. The clock lines come from an external source.

A small byte-wide register file sets the framing at run time:
- which bit-clock edge samples data;
- which word-clock level marks the left channel;
- MSB-first or LSB-first bit order;
- an optional one-bit delay between the word-clock transition and the first data bit;
- a limit on the bits per word-clock phase;
- the sample width.

A master enable bit picks between the programmed framing and a fixed built-in framing. The built-in framing samples on the rising bit-clock edge, puts left in the low word-clock phase, sends MSB first with no delay, and uses 16-bit phases carrying 16-bit samples. Two clock-direction bits are only stored and read back.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset every configuration register holds 0. Reads return 0 at addresses 0, 2, 3 and 4, and 0x12 at address 1. `valid_o`, `left_o` and `right_o` are 0.
- R2: While the enable bit (address 0, bit 0) is 0, the block uses the built-in framing whatever the other registers hold. The built-in framing is: rising-edge sampling, left in the low word-clock phase, MSB first, no delay, 16-bit phase limit, 16-bit samples.
- R3: Bit-clock polarity is address 1, bit 3. With the enable bit at 1, a value of 0 samples data on the rising bit-clock edge and 1 samples it on the falling edge.
- R4: Word-clock polarity is address 1, bit 6. With the enable bit at 1, a value of 0 assigns the low word-clock phase to the left channel and 1 assigns the high phase.
- R5: Bit order is address 2, bit 0. A value of 0 takes the first received bit as the sample MSB; 1 takes it as the LSB.
- R6: One-bit delay is address 2, bit 1. When it is 1, the bit sampled at the word-clock transition is skipped and the sample starts with the next bit.
- R7: Sample width is address 4 (values above 32 act as 32). Only the first width bits of a phase are kept, later bits in the phase are ignored, and the sample is right-justified in `left_o`/`right_o`.
- R8: Phase limit is address 3. Bits at positions at or beyond the limit in a phase are not captured. Sample bits left uncaptured read as 0, so an MSB-first sample from a short phase is zero-filled at its low end.
- R9: `valid_o` is high for exactly one system clock, on the third rising system clock after the pin edge that samples the first bit of the next left phase. `left_o`/`right_o` change only in that cycle.
- R10: The effective framing changes only through a register write. Any write discards the frame in progress, and the next strobe needs a complete left phase and right phase that begin after the write.
- R11: Address 1 always reads bit 0 and bit 7 as 0 and bit 1 and bit 4 as 1, whatever was written there. The direction bits (bit 2 for the bit clock, bit 5 for the word clock) read back as written and do not change reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock, selects left or right channel |
| sdata_i | input | 1 | Serial data |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address, used for both read and write |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for `cfg_addr_i` |
| left_o | output | MAX_W | Left sample, right-justified |
| right_o | output | MAX_W | Right sample, right-justified |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The bench builds the block with its defaults: MAX_W of 32, two synchroniser stages and a 3-bit address. The 32-bit width makes 24-bit and full 32-bit samples reachable, including phases longer than the sample. The two-stage synchroniser fixes the strobe at the third system clock after the sampling pin edge, and the bench checks that exact cycle after every stream. Every framing knob is driven with junk bits in the unused phase slots. A configuration write made mid-frame shows whether the partial frame is thrown away.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int REG_W = 8;

    localparam int ADDR_EN   = 0;
    localparam int ADDR_CLK  = 1;
    localparam int ADDR_FMT  = 2;
    localparam int ADDR_PLEN = 3;
    localparam int ADDR_SIZE = 4;

    // bit positions in the clock control byte
    localparam int CLK_RSV_ZERO_LO = 0;
    localparam int CLK_RSV_ONE_LO  = 1;
    localparam int CLK_BCK_DIR     = 2;
    localparam int CLK_BCK_POL     = 3;
    localparam int CLK_RSV_ONE_HI  = 4;
    localparam int CLK_LR_DIR      = 5;
    localparam int CLK_LR_POL      = 6;
    localparam int CLK_RSV_ZERO_HI = 7;

    localparam int FMT_LSB_FIRST = 0;
    localparam int FMT_DELAY1    = 1;

    typedef struct packed {
        logic             bck_pol;
        logic             lr_pol;
        logic             lsb_first;
        logic             delay1;
        logic [REG_W-1:0] phase_len;
        logic [REG_W-1:0] size;
    } fmt_t;

    localparam fmt_t FMT_DEFAULT = '{
        bck_pol:   1'b0,
        lr_pol:    1'b0,
        lsb_first: 1'b0,
        delay1:    1'b0,
        phase_len: REG_W'(16),
        size:      REG_W'(16)
    };

endpackage

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  cfg_rdata_o,
    output fmt_t              fmt_o,
    output logic              flush_o
);

    typedef struct packed {
        logic             en;
        logic             bck_dir;
        logic             bck_pol;
        logic             lr_dir;
        logic             lr_pol;
        logic             lsb_first;
        logic             delay1;
        logic [REG_W-1:0] phase_len;
        logic [REG_W-1:0] size;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_wr_i) begin
            case (cfg_addr_i)
                ADDR_W'(ADDR_EN): r_d.en = cfg_wdata_i[0];
                ADDR_W'(ADDR_CLK): begin
                    r_d.bck_dir = cfg_wdata_i[CLK_BCK_DIR];
                    r_d.bck_pol = cfg_wdata_i[CLK_BCK_POL];
                    r_d.lr_dir  = cfg_wdata_i[CLK_LR_DIR];
                    r_d.lr_pol  = cfg_wdata_i[CLK_LR_POL];
                end
                ADDR_W'(ADDR_FMT): begin
                    r_d.lsb_first = cfg_wdata_i[FMT_LSB_FIRST];
                    r_d.delay1    = cfg_wdata_i[FMT_DELAY1];
                end
                ADDR_W'(ADDR_PLEN): r_d.phase_len = cfg_wdata_i;
                ADDR_W'(ADDR_SIZE): r_d.size      = cfg_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux; reserved bits of the clock byte are fixed
    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_addr_i)
            ADDR_W'(ADDR_EN): cfg_rdata_o[0] = r_q.en;
            ADDR_W'(ADDR_CLK): begin
                cfg_rdata_o[CLK_RSV_ZERO_LO] = 1'b0;
                cfg_rdata_o[CLK_RSV_ONE_LO]  = 1'b1;
                cfg_rdata_o[CLK_BCK_DIR]     = r_q.bck_dir;
                cfg_rdata_o[CLK_BCK_POL]     = r_q.bck_pol;
                cfg_rdata_o[CLK_RSV_ONE_HI]  = 1'b1;
                cfg_rdata_o[CLK_LR_DIR]      = r_q.lr_dir;
                cfg_rdata_o[CLK_LR_POL]      = r_q.lr_pol;
                cfg_rdata_o[CLK_RSV_ZERO_HI] = 1'b0;
            end
            ADDR_W'(ADDR_FMT): begin
                cfg_rdata_o[FMT_LSB_FIRST] = r_q.lsb_first;
                cfg_rdata_o[FMT_DELAY1]    = r_q.delay1;
            end
            ADDR_W'(ADDR_PLEN): cfg_rdata_o = r_q.phase_len;
            ADDR_W'(ADDR_SIZE): cfg_rdata_o = r_q.size;
            default: ;
        endcase
    end

    // effective framing: programmed set or the built-in one
    always_comb begin
        if (r_q.en) begin
            fmt_o.bck_pol   = r_q.bck_pol;
            fmt_o.lr_pol    = r_q.lr_pol;
            fmt_o.lsb_first = r_q.lsb_first;
            fmt_o.delay1    = r_q.delay1;
            fmt_o.phase_len = r_q.phase_len;
            fmt_o.size      = r_q.size;
        end else begin
            fmt_o = FMT_DEFAULT;
        end
    end

    assign flush_o = cfg_wr_i;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(fmt_o)); // R10

endmodule

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = din;
        end else begin : g_chain
            always_comb stg_d = {stg_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/sar_deser.sv
module sar_deser
    import sar_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_t             fmt_i,
    input  logic             flush_i,
    input  logic             bck_i,
    input  logic             lr_i,
    input  logic             sd_i,
    output logic [MAX_W-1:0] left_o,
    output logic [MAX_W-1:0] right_o,
    output logic             valid_o
);

    localparam int               CNT_W   = REG_W;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(MAX_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [MAX_W-1:0] acc;
        logic [MAX_W-1:0] left_hold;
        logic [MAX_W-1:0] left_out;
        logic [MAX_W-1:0] right_out;
        logic             bck_prev;
        logic             lr_prev;
        logic             seen;
        logic             started;
        logic             left_ok;
        logic             valid;
    } st_t;

    st_t s_d, s_q;

    logic             samp;
    logic             trans;
    logic             take;
    logic [CNT_W-1:0] size_eff;
    logic [CNT_W-1:0] cnt_e;
    logic [CNT_W-1:0] dly;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] pos;
    logic [MAX_W-1:0] acc_new;

    always_comb begin
        s_d          = s_q;
        s_d.valid    = 1'b0;
        s_d.bck_prev = bck_i;

        samp     = fmt_i.bck_pol ? (s_q.bck_prev & ~bck_i) : (~s_q.bck_prev & bck_i);
        size_eff = (fmt_i.size > WIDTH_C) ? WIDTH_C : fmt_i.size;
        trans    = s_q.seen && (lr_i != s_q.lr_prev);
        cnt_e    = trans ? '0 : ((s_q.cnt == CNT_TOP) ? s_q.cnt : s_q.cnt + 1'b1);
        dly      = CNT_W'(fmt_i.delay1);
        idx      = cnt_e - dly;
        take     = (cnt_e >= dly) && (cnt_e < fmt_i.phase_len) && (idx < size_eff);
        pos      = fmt_i.lsb_first ? idx : (size_eff - 1'b1 - idx);

        acc_new = trans ? '0 : s_q.acc;
        for (int b = 0; b < MAX_W; b++) begin
            if (take && (pos == CNT_W'(b))) begin
                acc_new[b] = sd_i;
            end
        end

        if (flush_i) begin
            s_d.cnt     = '0;
            s_d.acc     = '0;
            s_d.started = 1'b0;
            s_d.left_ok = 1'b0;
        end else if (samp) begin
            s_d.seen    = 1'b1;
            s_d.lr_prev = lr_i;
            s_d.cnt     = cnt_e;
            s_d.acc     = acc_new;
            if (trans) begin
                s_d.started = 1'b1;
                if (s_q.started) begin
                    if (s_q.lr_prev == fmt_i.lr_pol) begin
                        s_d.left_hold = s_q.acc;
                        s_d.left_ok   = 1'b1;
                    end else if (s_q.left_ok) begin
                        s_d.left_out  = s_q.left_hold;
                        s_d.right_out = s_q.acc;
                        s_d.valid     = 1'b1;
                        s_d.left_ok   = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign left_o  = s_q.left_out;
    assign right_o = s_q.right_out;
    assign valid_o = s_q.valid;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(left_o) || !$stable(right_o)) |-> valid_o); // R9

    AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(samp)); // R9

    AST_FLUSH_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !valid_o); // R10

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int MAX_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  cfg_rdata_o,
    output logic [MAX_W-1:0]  left_o,
    output logic [MAX_W-1:0]  right_o,
    output logic              valid_o
);

    localparam int LINES = 3;

    fmt_t             fmt;
    logic             flush;
    logic [LINES-1:0] pins_sync;

    sar_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .fmt_o       (fmt),
        .flush_o     (flush)
    );

    sar_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({sdata_i, wclk_i, bclk_i}),
        .sync_o (pins_sync)
    );

    sar_deser #(
        .MAX_W (MAX_W)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_i   (fmt),
        .flush_i (flush),
        .bck_i   (pins_sync[0]),
        .lr_i    (pins_sync[1]),
        .sd_i    (pins_sync[2]),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck   = 1'b0;
    logic        lrck  = 1'b0;
    logic        sd    = 1'b0;
    logic        wr    = 1'b0;
    logic [2:0]  addr  = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [31:0] left, right;
    logic        valid;

    always #4 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bck),
        .wclk_i      (lrck),
        .sdata_i     (sd),
        .cfg_wr_i    (wr),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .left_o      (left),
        .right_o     (right),
        .valid_o     (valid)
    );

    int          n_chk = 0, n_fail = 0, n_got = 0, n_unstable = 0, n_wide = 0;
    logic [31:0] got_l [64];
    logic [31:0] got_r [64];
    logic [31:0] prev_l = '0, prev_r = '0;
    logic        prev_v = 1'b0;
    bit          done   = 1'b0;

    // monitor: records strobed pairs and output changes outside the strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                if (n_got < 64) begin
                    got_l[n_got] = left;
                    got_r[n_got] = right;
                end
                n_got++;
            end
            if (!valid && (left !== prev_l || right !== prev_r)) n_unstable++;
            if (valid && prev_v) n_wide++;
        end
        prev_l = left;
        prev_r = right;
        prev_v = valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        addr  = a;
        wdata = v;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, {24'b0, rdata}, {24'b0, exp}, "register read");
        @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int f, input int ch);
        return (32'h9E37_79B9 * (f * 2 + ch + 1)) ^ 32'hC3A5_5A3C;
    endfunction

    // value the receiver should hold for sample s under the given framing
    function automatic logic [31:0] expect_s(input logic [31:0] s, input int w, input int l,
                                             input int dl, input bit lsb);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < w; i++) begin
            if (i + dl < l) begin
                r[lsb ? i : w - 1 - i] = s[lsb ? i : w - 1 - i];
            end
        end
        return r;
    endfunction

    task automatic send_bit(input logic lr, input logic d, input logic bp);
        bck  = bp;
        lrck = lr;
        sd   = d;
        repeat (4) @(negedge clk);
        bck = ~bp;
        repeat (4) @(negedge clk);
    endtask

    // unused slots in a phase carry ones so that ignored bits are visible
    task automatic send_phase(input logic lr, input logic [31:0] s, input int w, input int l,
                              input int dl, input bit lsb, input logic bp);
        for (int k = 0; k < l; k++) begin
            int   i;
            logic d;
            i = k - dl;
            if (i >= 0 && i < w) d = s[lsb ? i : w - 1 - i];
            else d = 1'b1;
            send_bit(lr, d, bp);
        end
    endtask

    // first bit of the next left phase; strobe expected on the third clock (R9)
    task automatic trailer(input string req, input logic bp, input logic lp);
        bck  = bp;
        lrck = lp;
        sd   = 1'b0;
        repeat (4) @(negedge clk);
        bck = ~bp;
        @(negedge clk);
        chk("R9", {31'b0, valid}, 32'd0, {req, " strobe one clock after edge"});
        @(negedge clk);
        chk("R9", {31'b0, valid}, 32'd0, {req, " strobe two clocks after edge"});
        @(negedge clk);
        chk("R9", {31'b0, valid}, 32'd1, {req, " strobe three clocks after edge"});
        @(negedge clk);
        chk("R9", {31'b0, valid}, 32'd0, {req, " strobe four clocks after edge"});
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(input string req, input bit en, input logic [7:0] clkb,
                            input bit lsb, input bit dly, input int plen, input int size,
                            input int nfr);
        logic        bp, lp;
        bit          elsb;
        int          edl, epl, esz, n0;
        logic [31:0] mask, lv, rv;
        wr_reg(3'd1, clkb);
        wr_reg(3'd2, {6'b0, dly, lsb});
        wr_reg(3'd3, plen[7:0]);
        wr_reg(3'd4, size[7:0]);
        wr_reg(3'd0, {7'b0, en});
        bp   = en ? clkb[3] : 1'b0;
        lp   = en ? clkb[6] : 1'b0;
        elsb = en ? lsb : 1'b0;
        edl  = en ? int'(dly) : 0;
        epl  = en ? plen : 16;
        esz  = en ? ((size > 32) ? 32 : size) : 16;
        mask = (esz >= 32) ? 32'hFFFF_FFFF : ((32'h1 << esz) - 32'h1);
        n0   = n_got;
        bck  = ~bp;
        repeat (4) @(negedge clk);
        send_phase(~lp, 32'h0, esz, epl, edl, elsb, bp);
        for (int f = 0; f < nfr; f++) begin
            lv = pat(f, 0) & mask;
            rv = pat(f, 1) & mask;
            send_phase(lp, lv, esz, epl, edl, elsb, bp);
            send_phase(~lp, rv, esz, epl, edl, elsb, bp);
        end
        trailer(req, bp, lp);
        chk(req, n_got - n0, nfr, "strobe count");
        for (int f = 0; f < nfr; f++) begin
            chk(req, got_l[n0 + f], expect_s(pat(f, 0) & mask, esz, epl, edl, elsb), "left sample");
            chk(req, got_r[n0 + f], expect_s(pat(f, 1) & mask, esz, epl, edl, elsb), "right sample");
        end
    endtask

    // R10: a write in the middle of a right phase drops the partial frame
    task automatic flush_case();
        int n0;
        wr_reg(3'd0, 8'h00);
        n0  = n_got;
        bck = 1'b1;
        repeat (4) @(negedge clk);
        send_phase(1'b1, 32'h0, 16, 16, 0, 1'b0, 1'b0);
        send_phase(1'b0, pat(20, 0) & 32'hFFFF, 16, 16, 0, 1'b0, 1'b0);
        send_phase(1'b1, pat(20, 1) & 32'hFFFF, 16, 8, 0, 1'b0, 1'b0);
        wr_reg(3'd0, 8'h00);
        send_phase(1'b1, 32'h0, 16, 8, 0, 1'b0, 1'b0);
        send_phase(1'b0, pat(21, 0) & 32'hFFFF, 16, 16, 0, 1'b0, 1'b0);
        send_phase(1'b1, pat(21, 1) & 32'hFFFF, 16, 16, 0, 1'b0, 1'b0);
        trailer("R10", 1'b0, 1'b0);
        chk("R10", n_got - n0, 32'd1, "strobes after mid-frame write");
        chk("R10", got_l[n0], pat(21, 0) & 32'hFFFF, "left after flush");
        chk("R10", got_r[n0], pat(21, 1) & 32'hFFFF, "right after flush");
    endtask

    task automatic reset_case();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'b0, valid}, 32'd0, "valid after reset");
        chk("R1", left, 32'd0, "left after reset");
        chk("R1", right, 32'd0, "right after reset");
        rd_chk("R1", 3'd0, 8'h00);
        rd_chk("R1", 3'd1, 8'h12);
        rd_chk("R1", 3'd2, 8'h00);
        rd_chk("R1", 3'd3, 8'h00);
        rd_chk("R1", 3'd4, 8'h00);
    endtask

    initial begin
        reset_case();
        run_case("R2", 1'b0, 8'h48, 1'b1, 1'b1, 5, 7, 3);
        run_case("R3", 1'b1, 8'h1A, 1'b0, 1'b0, 16, 16, 3);
        run_case("R4", 1'b1, 8'h52, 1'b0, 1'b0, 16, 16, 3);
        run_case("R5", 1'b1, 8'h12, 1'b1, 1'b0, 16, 16, 3);
        run_case("R6", 1'b1, 8'h12, 1'b0, 1'b1, 32, 16, 2);
        run_case("R7", 1'b1, 8'h12, 1'b0, 1'b0, 32, 24, 2);
        run_case("R7", 1'b1, 8'h5A, 1'b1, 1'b0, 40, 40, 2);
        run_case("R8", 1'b1, 8'h12, 1'b0, 1'b0, 12, 16, 3);
        run_case("R11", 1'b1, 8'hA5, 1'b0, 1'b0, 16, 16, 2);
        rd_chk("R11", 3'd1, 8'h36);
        wr_reg(3'd1, 8'h00);
        rd_chk("R11", 3'd1, 8'h12);
        flush_case();
        chk("R9", n_unstable, 32'd0, "output changes without strobe");
        chk("R9", n_wide, 32'd0, "strobes longer than one clock");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule